// File: doc/BRIEF.md
# Lane-Aligned Vector Issue Steering

This block sits at the issue stage of a vector-capable core. Each incoming vector operation has a destination register and two source registers, and the block decides which kind of functional unit will execute it. Lane units are split into four groups, and the dependency matrices behind them are sparse. They can only take operations whose destination and two sources occupy the same position modulo four. Scalar units have full dependency coverage and can take any operand combination, but they retire one element per cycle. The block never issues an operation to lanes when no dependency cell covers its operands. Such operations go to the scalar units instead.

For a lane route the block issues up to four elements per cycle, one on each lane. Element i lands on lane (base + i) mod 4. For a scalar route it issues one element per cycle. An optional mixed mode covers single-element operations whose sources are lane-aligned but whose destination is not. These run their sources on a lane, and the block remembers the unaligned destination as pending. Any later operation that reads the pending register is held back until a writeback pulse for that register arrives.

Register numbers are 7 bits and wrap modulo 128. The vector length is 0 to 64.

Top module: `vec_lane_steer`

## Requirements
- R1: After reset the block is idle. `in_ready` is 1, `route` is 0, `stall` is 0, `done` is 0, and no lane or scalar element is valid.
- R2: When the low two bits of `in_dst`, `in_src1` and `in_src2` are all equal (both offsets are multiples of 4), the accepted operation gets `route` = 1 (lane) in every issue cycle.
- R3: When R2 does not hold and R9 does not apply, `route` = 2 (scalar). This includes an aligned src1/dst pair with a misaligned src2.
- R4: In lane issue cycle g (counting from 0), element i with 4g ≤ i < 4g+4 and i < VL is valid on lane (b + i) mod 4, and that lane's 6-bit field of `lane_elem` equals i. Lane l occupies bits [6l+5:6l]. The base b is the low two bits of `in_dst` for route 1 and of `in_src1` for route 3.
- R5: A lane-routed operation of length VL ≥ 1 issues in ceil(VL/4) consecutive cycles. `done` is 1 only in the last of them.
- R6: A scalar-routed operation issues element c in cycle c, with `scal_vld` = 1 and `scal_elem` = c, over VL cycles. No lane is valid, and `done` is 1 in the last cycle.
- R7: An operation is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Issue starts in the next cycle. `in_ready` stays 0 until the cycle after `done`.
- R8: An accepted operation with VL = 0 raises `done` in the next cycle, with no valid element.
- R9: With `mixed_en` = 1, VL = 1, src1 and src2 congruent mod 4, dst not congruent to src1, and nothing pending, the route is 3 (mixed). Exactly one lane, lane src1 mod 4, issues element 0, and dst becomes the pending register. If a register is already pending, the operation is routed as scalar.
- R10: While a register P is pending, `stall` = 1 and `in_ready` = 0 for any valid operation where (P − src) mod 128 < VL for src1 or src2.
- R11: A `wb_valid` pulse with `wb_reg` = P clears the pending register at that edge. `stall` is still 1 in the pulse cycle and 0 afterwards. A pulse for another register has no effect. Recording a new pending register takes priority over a clear in the same cycle.
- R12: With `mixed_en` = 0 nothing becomes pending. An operation that reads no pending register is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mixed_en | input | 1 | Enables the mixed aligned-source/unaligned-destination route |
| in_valid | input | 1 | Operation offered |
| in_vl | input | 7 | Vector length, 0 to 64 |
| in_dst | input | 7 | Destination base register |
| in_src1 | input | 7 | First source base register |
| in_src2 | input | 7 | Second source base register |
| in_ready | output | 1 | Operation can be accepted this cycle |
| stall | output | 1 | Offered operation reads the pending register |
| wb_valid | input | 1 | Writeback-complete pulse |
| wb_reg | input | 7 | Register whose write completed |
| route | output | 2 | 0 idle, 1 lane, 2 scalar, 3 mixed |
| lane_vld | output | 4 | Per-lane element valid |
| lane_elem | output | 24 | Per-lane element index, 6 bits per lane |
| scal_vld | output | 1 | Scalar element valid |
| scal_elem | output | 6 | Scalar element index |
| done | output | 1 | Last issue cycle of the current operation |

## Verification
Two functions can fall in the same cycle: a writeback clear of the pending register and either a stalled operation waiting on it or the recording of a new pending register. The bench holds a stalled operation on `in_valid` and pulses the writeback. It expects `stall` to stay high in the pulse cycle and the operation to be accepted on the following edge. Separately, the bench accepts a mixed operation in the same cycle as a writeback naming that same destination. A later reader of that register must then stall, which shows that the new entry won over the clear.

// File: rtl/vec_lane_steer.sv
module vec_lane_steer #(
  parameter int LANES = 4,
  parameter int RW    = 7,
  parameter int VLW   = 7,
  parameter int EW    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mixed_en,
  input  logic                 in_valid,
  input  logic [VLW-1:0]       in_vl,
  input  logic [RW-1:0]        in_dst,
  input  logic [RW-1:0]        in_src1,
  input  logic [RW-1:0]        in_src2,
  output logic                 in_ready,
  output logic                 stall,
  input  logic                 wb_valid,
  input  logic [RW-1:0]        wb_reg,
  output logic [1:0]           route,
  output logic [LANES-1:0]     lane_vld,
  output logic [LANES*EW-1:0]  lane_elem,
  output logic                 scal_vld,
  output logic [EW-1:0]        scal_elem,
  output logic                 done
);
  localparam int LB = $clog2(LANES);
  localparam int PW = VLW + 1;
  localparam logic [1:0] RT_IDLE = 2'd0, RT_LANE = 2'd1, RT_SCAL = 2'd2, RT_MIX = 2'd3;

  logic           busy, pend_v;
  logic [1:0]     route_q, route_d;
  logic [VLW-1:0] vl_q;
  logic [LB-1:0]  base_q;
  logic [PW-1:0]  pos_q;
  logic [RW-1:0]  pend_r;

  wire [LB-1:0] d1 = in_src1[LB-1:0] - in_dst[LB-1:0];
  wire [LB-1:0] d2 = in_src2[LB-1:0] - in_src1[LB-1:0];
  wire src_al = (d2 == '0);
  wire dst_al = (d1 == '0);
  wire mix_ok = mixed_en && src_al && !dst_al && (in_vl == VLW'(1)) && !pend_v;

  always_comb begin
    if (src_al && dst_al) route_d = RT_LANE;
    else if (mix_ok)      route_d = RT_MIX;
    else                  route_d = RT_SCAL;
  end

  wire [RW-1:0] h1 = pend_r - in_src1;
  wire [RW-1:0] h2 = pend_r - in_src2;
  wire hit1 = {{VLW{1'b0}}, h1} < {{RW{1'b0}}, in_vl};
  wire hit2 = {{VLW{1'b0}}, h2} < {{RW{1'b0}}, in_vl};

  assign stall    = in_valid && pend_v && (hit1 || hit2);
  assign in_ready = !busy && !stall;
  wire   take     = in_valid && in_ready;

  wire lane_mode = (route_q == RT_LANE) || (route_q == RT_MIX);
  wire [PW-1:0] step = lane_mode ? PW'(LANES) : PW'(1);
  wire [PW-1:0] vl_x = {1'b0, vl_q};

  assign done      = busy && ((pos_q + step) >= vl_x);
  assign route     = route_q;
  assign scal_vld  = busy && (route_q == RT_SCAL) && (pos_q < vl_x);
  assign scal_elem = pos_q[EW-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wire [LB-1:0] off = LB'(l) - base_q;
    wire [PW-1:0] e   = pos_q + PW'(off);
    assign lane_vld[l] = busy && lane_mode && (e < vl_x);
    assign lane_elem[l*EW +: EW] = e[EW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      route_q <= RT_IDLE;
      vl_q    <= '0;
      base_q  <= '0;
      pos_q   <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      route_q <= route_d;
      vl_q    <= in_vl;
      pos_q   <= '0;
      base_q  <= (route_d == RT_MIX) ? in_src1[LB-1:0] : in_dst[LB-1:0];
    end else if (done) begin
      busy    <= 1'b0;
      route_q <= RT_IDLE;
    end else if (busy) begin
      pos_q   <= pos_q + step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_r <= '0;
    end else if (take && route_d == RT_MIX) begin
      pend_v <= 1'b1;
      pend_r <= in_dst;
    end else if (wb_valid && pend_v && wb_reg == pend_r) begin
      pend_v <= 1'b0;
    end
  end
endmodule

// File: rtl/vec_lane_steer_chk.sv
module vec_lane_steer_chk #(
  parameter int LANES = 4,
  parameter int VLW   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mixed_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic [VLW-1:0]   in_vl,
  input logic [1:0]       dst_lo,
  input logic [1:0]       s1_lo,
  input logic [1:0]       s2_lo,
  input logic             stall,
  input logic [1:0]       route,
  input logic [LANES-1:0] lane_vld,
  input logic             scal_vld,
  input logic             done
);
  wire take = in_valid && in_ready;

  AST_SRC_SKEW_NOT_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    take && (s1_lo != s2_lo) |=> route != 2'd1); // R2
  AST_DST_SKEW_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
    take && !mixed_en && (dst_lo != s1_lo) |=> route == 2'd2); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    route == 2'd0 |-> (lane_vld == '0) && !scal_vld && !done); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_SCALAR_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    route == 2'd2 |-> lane_vld == '0); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    route != 2'd0 |-> !in_ready); // R7
  AST_TAKE_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> route != 2'd0); // R7
  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    take && (in_vl == '0) |=> done); // R8
  AST_MIX_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    route == 2'd3 |-> $countones(lane_vld) == 1); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !in_ready); // R10
endmodule

bind vec_lane_steer vec_lane_steer_chk #(.LANES(LANES), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mixed_en(mixed_en), .in_valid(in_valid),
  .in_ready(in_ready), .in_vl(in_vl), .dst_lo(in_dst[1:0]), .s1_lo(in_src1[1:0]),
  .s2_lo(in_src2[1:0]), .stall(stall), .route(route), .lane_vld(lane_vld),
  .scal_vld(scal_vld), .done(done)
);

// File: tb/sim_vec_lane_steer.sv
module sim_vec_lane_steer;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, mixed_en = 0, in_valid = 0, wb_valid = 0;
  logic [6:0] in_vl = 0, in_dst = 0, in_src1 = 0, in_src2 = 0, wb_reg = 0;
  logic in_ready, stall, scal_vld, done;
  logic [1:0] route;
  logic [3:0] lane_vld;
  logic [23:0] lane_elem;
  logic [5:0] scal_elem;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  vec_lane_steer u0 (
    .clk(clk), .rst_n(rst_n), .mixed_en(mixed_en), .in_valid(in_valid),
    .in_vl(in_vl), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_ready(in_ready), .stall(stall), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .route(route), .lane_vld(lane_vld), .lane_elem(lane_elem),
    .scal_vld(scal_vld), .scal_elem(scal_elem), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue_check(input string req, input int rt, input int base, input int vl);
    int n;
    if (rt == 2) n = (vl == 0) ? 1 : vl;
    else         n = (vl == 0) ? 1 : (vl + 3) / 4;
    for (int c = 0; c < n; c++) begin
      logic [3:0] ev = '0;
      int ee[4] = '{0, 0, 0, 0};
      if (rt != 2)
        for (int i = 4*c; i < 4*c + 4; i++)
          if (i < vl) begin
            ev[(base + i) % 4] = 1'b1;
            ee[(base + i) % 4] = i;
          end
      chk(req, "route", route, rt);
      chk(req, "lane_vld", lane_vld, ev);
      for (int l = 0; l < 4; l++)
        if (ev[l]) chk(req, "lane_elem", lane_elem[l*6 +: 6], ee[l]);
      chk(req, "scal_vld", scal_vld, (rt == 2 && c < vl) ? 1 : 0);
      if (rt == 2 && c < vl) chk(req, "scal_elem", scal_elem, c);
      chk(req, "done", done, (c == n - 1) ? 1 : 0);
      chk("R7", "in_ready during issue", in_ready, 0);
      @(negedge clk);
    end
    chk("R7", "in_ready after done", in_ready, 1);
    chk("R7", "route idle after done", route, 0);
  endtask

  task automatic send(input int d, input int s1, input int s2, input int vl,
                      input bit mx, input bit wbv, input int wbr);
    in_dst = 7'(d); in_src1 = 7'(s1); in_src2 = 7'(s2); in_vl = 7'(vl);
    mixed_en = mx; wb_valid = wbv; wb_reg = 7'(wbr); in_valid = 1;
    #1 chk("R12", "in_ready on offer", in_ready, 1);
    @(negedge clk);
    in_valid = 0; wb_valid = 0;
  endtask

  task automatic probe(input string req, input int s1, input int s2, input int vl, input bit exp_st);
    in_dst = 7'd64; in_src1 = 7'(s1); in_src2 = 7'(s2); in_vl = 7'(vl); in_valid = 1;
    #1;
    chk(req, "stall", stall, exp_st);
    chk(req, "in_ready vs stall", in_ready, !exp_st);
    #1 in_valid = 0;
    @(negedge clk);
  endtask

  task automatic wb_pulse(input int r);
    wb_valid = 1; wb_reg = 7'(r);
    @(negedge clk);
    wb_valid = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "route", route, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "done", done, 0);
    chk("R1", "lane_vld", lane_vld, 0);
    chk("R1", "scal_vld", scal_vld, 0);
  endtask

  task automatic t_aligned;
    send(0, 16, 32, 12, 0, 0, 0);
    issue_check("R2 R4 R5", 1, 0, 12);
  endtask

  task automatic t_offset_base;
    send(1, 5, 9, 6, 0, 0, 0);
    issue_check("R4", 1, 1, 6);
  endtask

  task automatic t_misaligned;
    send(0, 17, 25, 12, 0, 0, 0);
    issue_check("R3 R6", 2, 0, 12);
  endtask

  task automatic t_src2_skew;
    send(0, 16, 33, 3, 1, 0, 0);
    issue_check("R3", 2, 0, 3);
  endtask

  task automatic t_vl0;
    send(0, 16, 32, 0, 0, 0, 0);
    issue_check("R8", 1, 0, 0);
  endtask

  task automatic t_mix_off;
    send(7, 16, 32, 1, 0, 0, 0);
    issue_check("R12", 2, 0, 1);
    probe("R12", 7, 7, 1, 0);
  endtask

  task automatic t_mix;
    send(7, 16, 32, 1, 1, 0, 0);
    issue_check("R9", 3, 0, 1);
  endtask

  task automatic t_pend_busy;
    send(3, 16, 32, 1, 1, 0, 0);
    issue_check("R9", 2, 0, 1);
    probe("R12", 16, 32, 4, 0);
  endtask

  task automatic t_stall;
    in_dst = 7'd40; in_src1 = 7'd4; in_src2 = 7'd8; in_vl = 7'd4; mixed_en = 0; in_valid = 1;
    #1 chk("R10", "stall on reader", stall, 1);
    chk("R10", "in_ready on reader", in_ready, 0);
    @(negedge clk);
    wb_valid = 1; wb_reg = 7'd9;
    #1 chk("R10", "stall held", stall, 1);
    @(negedge clk);
    wb_valid = 0;
    #1 chk("R11", "other wb no effect", stall, 1);
    @(negedge clk);
    wb_valid = 1; wb_reg = 7'd7;
    #1 chk("R11", "stall in clear cycle", stall, 1);
    @(negedge clk);
    wb_valid = 0;
    #1 chk("R11", "stall after clear", stall, 0);
    chk("R11", "in_ready after clear", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    issue_check("R11", 1, 0, 4);
  endtask

  task automatic t_same_cycle;
    send(11, 20, 24, 1, 1, 1, 11);
    issue_check("R9", 3, 0, 1);
    probe("R11", 11, 11, 1, 1);
    wb_pulse(11);
    probe("R11", 11, 11, 1, 0);
  endtask

  task automatic t_wrap;
    send(2, 16, 32, 1, 1, 0, 0);
    issue_check("R9", 3, 0, 1);
    probe("R10", 126, 126, 4, 0);
    probe("R10", 126, 126, 5, 1);
    probe("R10", 40, 126, 5, 1);
    wb_pulse(2);
    probe("R11", 126, 126, 5, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_aligned();
    t_offset_base();
    t_misaligned();
    t_src2_skew();
    t_vl0();
    t_mix_off();
    t_mix();
    t_pend_busy();
    t_stall();
    t_same_cycle();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule